// File: doc/BRIEF.md
# Per-Bit Attribute Register Bank

This block is a small bank of 32-bit control and status registers reached through a simple memory-mapped port. The port has separate read and write strobes, a byte address and an access-size input in bytes. Each register has its own reset value and five per-bit attribute masks:

- **fixed**: read-only.
- **clear by writing 1**: a bit written as one is cleared.
- **reserved**: the bit never changes.
- **clear when read**: a read zeroes the bit.
- **not implemented**: writing a one here is flagged.

The bank applies these attributes on every access. Writes are merged under a byte-enable mask derived from the access size. A read can change state, because it zeroes the clear-when-read bits that it covers.

Hardware logic raises event bits through a per-register set input. The set input acts only on the bits marked clear-by-writing-1 or clear-when-read, and it wins against a software clear in the same cycle. Three sticky error outputs report illegal accesses:

- an access to an undefined address;
- a write that changes a reserved bit;
- a write that sets an unimplemented bit.

A single clear input drops all three flags. The full contents of every register are driven out in parallel, so that the surrounding hardware can use them.

Top module: `csr_bank`

## Requirements
- R1: After reset, each register holds its own reset value, all three error flags are 0 and `rd_valid` is 0.
- R2: Register k answers only at byte address 4*k. A misaligned address (low two bits not 00) is undefined, and so is any index of NUM_REGS or more.
- R3: An access size of N bytes enables bit lanes 0 to min(N,4)*8-1 for both writes and reads. A size of 0 enables no lane.
- R4: On a write to a defined register, each enabled bit that is not read-only, not clear-by-writing-1 and not reserved takes the write data. Every other bit keeps its old value.
- R5: On a write, an enabled clear-by-writing-1 bit written as 1 is cleared. One written as 0, or one outside the enabled lanes, is unchanged.
- R6: A read alone asserts `rd_valid` for one cycle, one clock after the strobe. `rd_data` then carries the register value masked to the enabled lanes. The clear-when-read bits inside those lanes are zeroed on the same clock edge.
- R7: A read of an undefined address returns 0 with `rd_valid` set. A write to an undefined address changes no register. Both kinds of access set `err_addr`.
- R8: A write to a defined register whose data differs from the current value in any reserved bit sets `err_rsvd`. The full data word is compared, whatever the access size.
- R9: A write to a defined register whose data has a 1 in any unimplemented bit sets `err_unimp`.
- R10: The error flags stay set until `err_clr` is asserted. A new error in the same cycle as `err_clr` leaves its flag set.
- R11: `hw_set` bit k*32+b sets bit b of register k only if that bit is clear-by-writing-1 or clear-when-read, and it wins over a software clear in the same cycle. On any other bit, `hw_set` has no effect.
- R12: When `wr_en` and `rd_en` are high together, only the write is carried out. `rd_valid` stays 0 and no clear-when-read bit is zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| size | input | SIZE_W | Access size in bytes |
| wr_data | input | 32 | Write data |
| hw_set | input | NUM_REGS*32 | Hardware set bits, register k in bits k*32 and up |
| err_clr | input | 1 | Clears all error flags |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| err_addr | output | 1 | Sticky undefined-address flag |
| err_rsvd | output | 1 | Sticky reserved-bit change flag |
| err_unimp | output | 1 | Sticky unimplemented-bit flag |
| regs_out | output | NUM_REGS*32 | Current contents of all registers |

## Verification
The write merge is tried with every access size from 0 to 8, against registers whose attribute mixes differ. A wrong lane mask then shows up separately from a wrong attribute mask. Some reads hit clear-when-read bits that lie outside the read lanes, which tells a read-masked clear from an unmasked one. Some `hw_set` pulses coincide with a write-one clear of the same bit, and others land on plain bits, which checks the priority of set over clear and the attribute filter. Undefined, misaligned and out-of-range addresses are mixed in among legal ones. A long random stream, with sparse hardware sets and error clears, then exercises the combinations.

// File: rtl/csr_pkg.sv
`timescale 1ns/1ps
package csr_pkg;
    localparam int WORD_W  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = WORD_W / LANE_W;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/csr_decode.sv
`timescale 1ns/1ps
module csr_decode #(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 6
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] hit,
    output logic                valid
);
    // one comparator per register location at byte offset 4*k
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
        assign hit[k] = (addr == ADDR_W'(k * 4));
    end
    assign valid = |hit;
endmodule

// File: rtl/csr_bytemask.sv
`timescale 1ns/1ps
module csr_bytemask
    import csr_pkg::*;
#(
    parameter int SIZE_W = 4
) (
    input  logic [SIZE_W-1:0] size,
    output word_t             mask
);
    // lane b is enabled when the access covers more than b bytes
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign mask[b*LANE_W +: LANE_W] = {LANE_W{size > SIZE_W'(b)}};
    end
endmodule

// File: rtl/csr_word.sv
`timescale 1ns/1ps
module csr_word
    import csr_pkg::*;
#(
    parameter word_t RO_M    = '0,
    parameter word_t W1C_M   = '0,
    parameter word_t RSVD_M  = '0,
    parameter word_t COR_M   = '0,
    parameter word_t UNIMP_M = '0
) (
    input  word_t cur,
    input  word_t wdata,
    input  word_t mask,
    input  logic  wr_hit,
    input  logic  rd_hit,
    input  word_t hw_set,
    output word_t nxt,
    output word_t rd_val,
    output logic  rsvd_err,
    output logic  unimp_err
);
    localparam word_t KEEP_M = RO_M | W1C_M | RSVD_M;
    localparam word_t EVT_M  = W1C_M | COR_M;

    word_t no_wr;

    always_comb begin
        no_wr = KEEP_M | ~mask;
        nxt   = cur;
        if (wr_hit) begin
            nxt = (wdata & ~no_wr) | (cur & no_wr);
            nxt = nxt & ~(wdata & W1C_M & mask);
        end else if (rd_hit) begin
            nxt = cur & ~(COR_M & mask);
        end
        // hardware events win over any software clear
        nxt       = nxt | (hw_set & EVT_M);
        rsvd_err  = wr_hit && (|((cur ^ wdata) & RSVD_M));
        unimp_err = wr_hit && (|(wdata & UNIMP_M));
        rd_val    = cur & mask;
    end
endmodule

// File: rtl/csr_bank.sv
`timescale 1ns/1ps
module csr_bank
    import csr_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 6,
    parameter int SIZE_W   = 4,
    parameter logic [NUM_REGS*WORD_W-1:0] RESET_VALS  =
        {32'h1234_5678, 32'h0000_1200, 32'h0000_0000, 32'h0000_00A5},
    parameter logic [NUM_REGS*WORD_W-1:0] RO_MASKS    =
        {32'h0000_0000, 32'h0000_FF00, 32'h0000_0000, 32'hFF00_0000},
    parameter logic [NUM_REGS*WORD_W-1:0] W1C_MASKS   =
        {32'h0F00_0000, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0000},
    parameter logic [NUM_REGS*WORD_W-1:0] RSVD_MASKS  =
        {32'hF000_0000, 32'h0000_0000, 32'hFFFF_0000, 32'h00F0_0000},
    parameter logic [NUM_REGS*WORD_W-1:0] COR_MASKS   =
        {32'h00F0_0000, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0000},
    parameter logic [NUM_REGS*WORD_W-1:0] UNIMP_MASKS =
        {32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 32'h000F_0000}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [SIZE_W-1:0]          size,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic [NUM_REGS*WORD_W-1:0] hw_set,
    input  logic                       err_clr,
    output logic [WORD_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic                       err_addr,
    output logic                       err_rsvd,
    output logic                       err_unimp,
    output logic [NUM_REGS*WORD_W-1:0] regs_out
);
    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] regs;
        logic [WORD_W-1:0]               rdata;
        logic                            rvalid;
        logic                            e_addr;
        logic                            e_rsvd;
        logic                            e_unimp;
    } state_t;

    localparam state_t RST_STATE = '{
        regs:    RESET_VALS,
        rdata:   '0,
        rvalid:  1'b0,
        e_addr:  1'b0,
        e_rsvd:  1'b0,
        e_unimp: 1'b0
    };

    state_t s_d, s_q;

    logic [NUM_REGS-1:0]             hit;
    logic                            addr_ok;
    word_t                           lane_mask;
    logic [NUM_REGS-1:0]             wr_hit, rd_hit;
    logic [NUM_REGS-1:0][WORD_W-1:0] nxt, rd_val;
    logic [NUM_REGS-1:0]             rsvd_hit, unimp_hit;

    csr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
        .addr  (addr),
        .hit   (hit),
        .valid (addr_ok)
    );

    csr_bytemask #(.SIZE_W(SIZE_W)) u_mask (
        .size (size),
        .mask (lane_mask)
    );

    // a concurrent write takes precedence over a read
    assign wr_hit = hit & {NUM_REGS{wr_en}};
    assign rd_hit = hit & {NUM_REGS{rd_en & ~wr_en}};

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
        csr_word #(
            .RO_M    (RO_MASKS   [k*WORD_W +: WORD_W]),
            .W1C_M   (W1C_MASKS  [k*WORD_W +: WORD_W]),
            .RSVD_M  (RSVD_MASKS [k*WORD_W +: WORD_W]),
            .COR_M   (COR_MASKS  [k*WORD_W +: WORD_W]),
            .UNIMP_M (UNIMP_MASKS[k*WORD_W +: WORD_W])
        ) u_word (
            .cur       (s_q.regs[k]),
            .wdata     (wr_data),
            .mask      (lane_mask),
            .wr_hit    (wr_hit[k]),
            .rd_hit    (rd_hit[k]),
            .hw_set    (hw_set[k*WORD_W +: WORD_W]),
            .nxt       (nxt[k]),
            .rd_val    (rd_val[k]),
            .rsvd_err  (rsvd_hit[k]),
            .unimp_err (unimp_hit[k])
        );
    end

    always_comb begin
        s_d        = s_q;
        s_d.regs   = nxt;
        s_d.rvalid = rd_en & ~wr_en;
        s_d.rdata  = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_hit[k]) begin
                s_d.rdata = s_d.rdata | rd_val[k];
            end
        end
        s_d.e_addr  = (s_q.e_addr  & ~err_clr) | ((wr_en | rd_en) & ~addr_ok);
        s_d.e_rsvd  = (s_q.e_rsvd  & ~err_clr) | (|rsvd_hit);
        s_d.e_unimp = (s_q.e_unimp & ~err_clr) | (|unimp_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= RST_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data   = s_q.rdata;
    assign rd_valid  = s_q.rvalid;
    assign err_addr  = s_q.e_addr;
    assign err_rsvd  = s_q.e_rsvd;
    assign err_unimp = s_q.e_unimp;
    assign regs_out  = s_q.regs;
endmodule

// File: rtl/csr_bank_chk.sv
`timescale 1ns/1ps
module csr_bank_chk #(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 6,
    parameter logic [NUM_REGS*32-1:0] RO_MASKS   = '0,
    parameter logic [NUM_REGS*32-1:0] W1C_MASKS  = '0,
    parameter logic [NUM_REGS*32-1:0] RSVD_MASKS = '0,
    parameter logic [NUM_REGS*32-1:0] COR_MASKS  = '0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [ADDR_W-1:0]      addr,
    input logic                   err_clr,
    input logic                   rd_valid,
    input logic                   err_addr,
    input logic                   err_rsvd,
    input logic                   err_unimp,
    input logic [NUM_REGS*32-1:0] regs_out
);
    localparam logic [NUM_REGS*32-1:0] FIXED =
        (RO_MASKS | RSVD_MASKS) & ~(W1C_MASKS | COR_MASKS);

    logic bad_addr;
    assign bad_addr = (addr[1:0] != 2'b00) ||
                      ({{(32-ADDR_W+2){1'b0}}, addr[ADDR_W-1:2]} >= NUM_REGS);

    // R6
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rd_valid);

    // R12
    wr_over_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_valid);

    // R7
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && bad_addr) |=> err_addr);

    // R10
    sticky_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_addr && !err_clr) |=> err_addr);

    // R10
    sticky_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rsvd && !err_clr) |=> err_rsvd);

    // R10
    sticky_unimp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_unimp && !err_clr) |=> err_unimp);

    // R4
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((regs_out ^ $past(regs_out)) & FIXED) == '0));
endmodule

bind csr_bank csr_bank_chk #(
    .NUM_REGS   (NUM_REGS),
    .ADDR_W     (ADDR_W),
    .RO_MASKS   (RO_MASKS),
    .W1C_MASKS  (W1C_MASKS),
    .RSVD_MASKS (RSVD_MASKS),
    .COR_MASKS  (COR_MASKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .err_clr   (err_clr),
    .rd_valid  (rd_valid),
    .err_addr  (err_addr),
    .err_rsvd  (err_rsvd),
    .err_unimp (err_unimp),
    .regs_out  (regs_out)
);

// File: tb/tb_csr_bank.sv
`timescale 1ns/1ps
module tb_csr_bank;
    localparam int N = 4;
    localparam logic [31:0] RV  [N] = '{32'h0000_00A5, 32'h0000_0000, 32'h0000_1200, 32'h1234_5678};
    localparam logic [31:0] ROM [N] = '{32'hFF00_0000, 32'h0000_0000, 32'h0000_FF00, 32'h0000_0000};
    localparam logic [31:0] W1M [N] = '{32'h0000_0000, 32'h0000_00FF, 32'h0000_0000, 32'h0F00_0000};
    localparam logic [31:0] RSM [N] = '{32'h00F0_0000, 32'hFFFF_0000, 32'h0000_0000, 32'hF000_0000};
    localparam logic [31:0] CRM [N] = '{32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 32'h00F0_0000};
    localparam logic [31:0] UIM [N] = '{32'h000F_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, err_clr = 1'b0;
    logic [5:0]    addr = '0;
    logic [3:0]    size = '0;
    logic [31:0]   wr_data = '0;
    logic [N*32-1:0] hw_set = '0;
    logic [31:0]   rd_data;
    logic          rd_valid, err_addr, err_rsvd, err_unimp;
    logic [N*32-1:0] regs_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] m [N];
    logic        f_addr, f_rsvd, f_unimp, x_rv;
    logic [31:0] x_rd;

    always #2.5 clk = ~clk;

    csr_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .size(size), .wr_data(wr_data), .hw_set(hw_set), .err_clr(err_clr),
        .rd_data(rd_data), .rd_valid(rd_valid), .err_addr(err_addr),
        .err_rsvd(err_rsvd), .err_unimp(err_unimp), .regs_out(regs_out)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] sz);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++) if (sz > 4'(b)) r[b*8 +: 8] = 8'hFF;
        return r;
    endfunction

    task automatic check_all(input string tag);
        for (int k = 0; k < N; k++) check(tag, $sformatf("reg%0d", k), regs_out[k*32 +: 32], m[k]);
        check(tag, "rd_valid", 32'(rd_valid), 32'(x_rv));
        if (x_rv) check(tag, "rd_data", rd_data, x_rd);
        check(tag, "err_addr", 32'(err_addr), 32'(f_addr));
        check(tag, "err_rsvd", 32'(err_rsvd), 32'(f_rsvd));
        check(tag, "err_unimp", 32'(err_unimp), 32'(f_unimp));
    endtask

    // one bus cycle: model update from the requirements, drive, clock, compare
    task automatic op(input bit wr, input bit rd, input logic [5:0] a, input logic [3:0] sz,
                      input logic [31:0] wd, input logic [N*32-1:0] hw, input bit clr,
                      input string tag);
        logic [31:0] mk = lanes(sz);
        bit ok = (a[1:0] == 2'b00) && (a[5:2] < 4'(N));
        int ix = int'(a[5:2]);
        logic [31:0] wm;
        bit e_r = 0, e_u = 0;
        x_rv = rd && !wr;
        x_rd = '0;
        if (wr && ok) begin
            wm = mk & ~(ROM[ix] | W1M[ix] | RSM[ix]);
            e_r = |((m[ix] ^ wd) & RSM[ix]);
            e_u = |(wd & UIM[ix]);
            m[ix] = (m[ix] & ~wm) | (wd & wm);
            m[ix] = m[ix] & ~(wd & W1M[ix] & mk);
        end else if (rd && !wr && ok) begin
            x_rd = m[ix] & mk;
            m[ix] = m[ix] & ~(CRM[ix] & mk);
        end
        for (int k = 0; k < N; k++) m[k] = m[k] | (hw[k*32 +: 32] & (W1M[k] | CRM[k]));
        f_addr  = (f_addr  && !clr) || ((wr || rd) && !ok);
        f_rsvd  = (f_rsvd  && !clr) || e_r;
        f_unimp = (f_unimp && !clr) || e_u;
        wr_en = wr; rd_en = rd; addr = a; size = sz; wr_data = wd; hw_set = hw; err_clr = clr;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; hw_set = '0; err_clr = 0;
        check_all(tag);
    endtask

    function automatic logic [N*32-1:0] hwk(input int k, input logic [31:0] v);
        logic [N*32-1:0] r = '0;
        r[k*32 +: 32] = v;
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed = $urandom(32'h1F2E3D4C);
        for (int k = 0; k < N; k++) m[k] = RV[k];
        f_addr = 0; f_rsvd = 0; f_unimp = 0; x_rv = 0; x_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R3: one-byte write touches only lane 0; size 0 writes nothing
        op(1, 0, 6'h00, 4'd1, 32'h000F_00FF, '0, 0, "R3");
        op(1, 0, 6'h00, 4'd0, 32'h0000_1111, '0, 0, "R3");
        op(1, 0, 6'h00, 4'd8, 32'h1200_5678, '0, 1, "R3");
        // R4: attributes on reg0 and reg2
        op(1, 0, 6'h00, 4'd4, 32'hAB00_CDEF, '0, 0, "R4");
        op(1, 0, 6'h08, 4'd2, 32'h0000_FFFF, '0, 0, "R4");
        // R11: hw set on event bits, ignored on plain bits
        op(0, 0, 6'h00, 4'd4, 32'h0, hwk(1, 32'h0000_00FF) | hwk(0, 32'hFFFF_FFFF), 0, "R11");
        // R5: clear by writing 1, lanes respected
        op(1, 0, 6'h04, 4'd4, 32'h0000_00F0, '0, 0, "R5");
        op(1, 0, 6'h04, 4'd0, 32'h0000_000F, '0, 0, "R5");
        // R11: set wins over software clear in the same cycle
        op(1, 0, 6'h04, 4'd4, 32'h0000_0001, hwk(1, 32'h0000_0001), 0, "R11");
        // R6: clear-when-read inside and outside the read lanes
        op(0, 0, 6'h00, 4'd4, 32'h0, hwk(2, 32'h0000_003C) | hwk(3, 32'h00F0_0000), 0, "R6");
        op(0, 1, 6'h0C, 4'd2, 32'h0, '0, 0, "R6");
        op(0, 1, 6'h0C, 4'd4, 32'h0, '0, 0, "R6");
        op(0, 1, 6'h08, 4'd1, 32'h0, '0, 0, "R6");
        // R2 + R7: defined, out-of-range and misaligned addresses
        op(1, 0, 6'h0C, 4'd4, 32'h1000_9999, '0, 0, "R2");
        op(0, 1, 6'h10, 4'd4, 32'h0, '0, 0, "R7");
        op(1, 0, 6'h02, 4'd4, 32'hFFFF_FFFF, '0, 0, "R7");
        // R10: clear with and without a coincident error
        op(0, 1, 6'h3C, 4'd4, 32'h0, '0, 1, "R10");
        op(0, 0, 6'h00, 4'd4, 32'h0, '0, 1, "R10");
        // R8: reserved change on reg3, even for a one-byte write
        op(1, 0, 6'h0C, 4'd1, 32'h0000_0000, '0, 0, "R8");
        // R9: unimplemented bit on reg2
        op(1, 0, 6'h08, 4'd4, 32'h8000_0000, '0, 0, "R9");
        op(0, 0, 6'h00, 4'd4, 32'h0, hwk(2, 32'h0000_00FF), 1, "R10");
        // R12: write and read together
        op(1, 1, 6'h08, 4'd4, 32'h0000_0000, '0, 0, "R12");

        // random stream mixing all features
        for (int i = 0; i < 600; i++) begin
            logic [5:0] a;
            logic [N*32-1:0] hw = '0;
            bit wr = ($urandom % 3) == 0;
            bit rd = ($urandom % 2) == 0;
            a = (($urandom % 8) == 0) ? 6'($urandom) : {2'b00, 2'($urandom), 2'b00};
            if (($urandom % 4) == 0) hw = {$urandom, $urandom, $urandom, $urandom} &
                                          {N{32'h0101_0101 << ($urandom % 8)}};
            op(wr, rd, a, 4'($urandom % 9), $urandom, hw, ($urandom % 10) == 0, "R4/R5/R6/R11");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule